// File: doc/BRIEF.md
# Free-Running Timer with Handshake-Cleared Status Flags

This block is a 16-bit free-running counter peripheral on an 8-bit register bus. The counter advances by one on every cycle in which the count-enable tick is high. Three events are recorded as sticky status flags:

- the counter wrapping past its top value;
- a rising edge on the capture input, which also copies the counter into a capture register;
- the counter reaching the value in a 16-bit compare register, which also drives a programmable level onto the compare output pin.

A flag is cleared only by a two-step sequence. Software first reads the status register while the flag is set, which arms that flag's clear. It then touches the flag's companion register. The counter is visible twice, through a main pair and an alternate pair. Only the main low byte takes part in clearing the overflow flag. Software can therefore sample elapsed time through the alternate pair without losing a pending overflow.

Each counter view has its own low-byte buffer. Reading a view's high byte freezes that view's low byte, so two byte reads form one coherent 16-bit value. The interrupt request is the OR of the flags that have their enable bit set.

The bus is a plain register port with no back-pressure:

- a read or write takes effect at the clock edge where `rd_i` or `wr_i` is high;
- `rdata_o` is combinational from `addr_i` and the current state;
- reads and writes are never stalled.

Top module: `frc_timer`

## Requirements
- R1: The status register is at address 1. It reads the capture flag at bit 7, the compare flag at bit 6 and the overflow flag at bit 5. Bits 4 to 0 read 0. Unmapped addresses (10 to 15) read 0.
- R2: A write to the status register changes no flag. The reset input leaves all three flags at their value. Reset clears the counter to 0, the control register to 0 and the compare register to 0xFFFF.
- R3: The counter increments by one per cycle with `tick_i` high. It wraps from 0xFFFF to 0x0000, and that wrap sets the overflow flag.
- R4: A read of the counter low byte at address 3 clears the overflow flag when it follows a status read that saw the overflow flag set.
- R5: The alternate pair reads the same value as the main pair: high byte at address 4, low byte at address 5. Reading the alternate pair never clears the overflow flag.
- R6: Reading a high byte copies the same view's low byte into that view's buffer. The main high byte is at address 2 and the alternate high byte at address 4. The next low-byte read of that view returns the buffered value and releases the buffer.
- R7: A rising edge of `cap_i` copies the counter into the capture register and sets the capture flag. The capture register reads high at address 6 and low at address 7. A read of address 7 after an armed status read clears the capture flag.
- R8: A compare match occurs on the tick that moves the counter onto the compare value. The compare register is written high at address 8 and low at address 9. A match sets the compare flag and loads `cmp_o` with control bit 0, the control register being at address 0. A write to address 9 after an armed status read clears the compare flag.
- R9: A write to the compare high byte suppresses matches until the compare low byte is written.
- R10: A status read arms a flag's clear only if that flag was set at the read. A flag event in the same cycle as the clearing access leaves the flag set.
- R11: `irq_o` is high when any flag is set together with its enable bit. The enables are control bits 7 (capture), 6 (compare) and 5 (overflow). The control register reads back bits 7 to 5 and bit 0, and its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (the flags do not take part in it) |
| tick_i | input | 1 | Count enable, one increment per high cycle |
| cap_i | input | 1 | Capture input; a rising edge triggers a capture |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| cmp_o | output | 1 | Compare output latch |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench runs the counter through a full wrap. It then reads the alternate pair while the overflow clear is armed. A design that decoded the alternate low byte as a clearing access would drop the overflow flag there.

Further cases:
- A low byte is read several ticks after its high byte. A design without per-view buffering would return a torn value.
- A capture edge is placed in the very cycle of the armed clearing read. A design that let the clear win would lose an event.
- A status read is made with a flag clear, followed by the companion access. A design that armed regardless of the flag would clear the flag later.
- The counter is run past a compare value after only its high byte was rewritten. A design without the inhibit would match against a half-written value.
- Reset is pulsed while a flag is set. A design that reset the flags would lose it.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 4;
  localparam int NREG   = 1 << ADDR_W;
  localparam int NFLAG  = 3;
  localparam int NVIEW  = 2;

  // flag indices; status/control bit = index + 5
  localparam int FI_TO = 0;
  localparam int FI_OC = 1;
  localparam int FI_IC = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd1;
  localparam logic [ADDR_W-1:0] A_CNTH = 4'd2;
  localparam logic [ADDR_W-1:0] A_CNTL = 4'd3;
  localparam logic [ADDR_W-1:0] A_ALTH = 4'd4;
  localparam logic [ADDR_W-1:0] A_ALTL = 4'd5;
  localparam logic [ADDR_W-1:0] A_CAPH = 4'd6;
  localparam logic [ADDR_W-1:0] A_CAPL = 4'd7;
  localparam logic [ADDR_W-1:0] A_CMPH = 4'd8;
  localparam logic [ADDR_W-1:0] A_CMPL = 4'd9;
endpackage

// File: rtl/frc_counter.sv
module frc_counter #(
  parameter int DW    = 8,
  parameter int NV    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic [NV-1:0]        rd_hi_i,
  input  logic [NV-1:0]        rd_lo_i,
  output logic [2*DW-1:0]      cnt_o,
  output logic                 wrap_o,
  output logic [NV-1:0][DW-1:0] lo_o
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (&cnt_q);

  // R3: one step per tick, modulo 2^CW
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> cnt_q == CW'($past(cnt_q) + CW'(1)));

  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));

  for (genvar g = 0; g < NV; g++) begin : g_view
    logic [DW-1:0] buf_q;
    logic          lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q <= '0;
        lat_q <= 1'b0;
      end else if (rd_hi_i[g]) begin
        buf_q <= cnt_q[DW-1:0];
        lat_q <= 1'b1;
      end else if (rd_lo_i[g]) begin
        lat_q <= 1'b0;
      end
    end

    assign lo_o[g] = lat_q ? buf_q : cnt_q[DW-1:0];

    // R6: after a high-byte read the low view is frozen at the old count
    p_coherent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi_i[g] |=> lo_o[g] == $past(cnt_q[DW-1:0]));
  end
endmodule

// File: rtl/frc_flag.sv
module frc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic look_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic arm_q;

  // flag is deliberately outside the reset domain
  always_ff @(posedge clk) begin
    if (set_i)               flag_q <= 1'b1;
    else if (clr_i && arm_q) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_q <= 1'b0;
    else if (look_i) arm_q <= flag_q;
    else if (clr_i)  arm_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R10: an event beats a simultaneous clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  // R4: armed access with no event clears
  p_armed_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q && clr_i && !set_i |=> !flag_q);

  // R10: a look at a clear flag never arms
  p_arm_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    look_i && !flag_q |=> !arm_q);
endmodule

// File: rtl/frc_compare.sv
module frc_compare #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic [2*DW-1:0] cnt_i,
  input  logic            wr_hi_i,
  input  logic            wr_lo_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            olvl_i,
  output logic [2*DW-1:0] cmp_o,
  output logic            match_o,
  output logic            pin_o
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] cmp_q;
  logic [CW-1:0] cnt_next;
  logic          inh_q;
  logic          pin_q;

  assign cnt_next = cnt_i + CW'(1);
  assign match_o  = tick_i && !inh_q && (cnt_next == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
      inh_q <= 1'b0;
    end else if (wr_hi_i) begin
      cmp_q[CW-1:DW] <= wdata_i;
      inh_q          <= 1'b1;
    end else if (wr_lo_i) begin
      cmp_q[DW-1:0]  <= wdata_i;
      inh_q          <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pin_q <= 1'b0;
    else if (match_o) pin_q <= olvl_i;
  end

  assign cmp_o = cmp_q;
  assign pin_o = pin_q;

  // R9: a lone high-byte write blocks the next cycle's match
  p_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_i |=> !match_o);

  // R8: pin takes the level selected at the match
  p_pin_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> pin_o == $past(olvl_i));

  p_pin_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !match_o |=> $stable(pin_o));
endmodule

// File: rtl/frc_timer.sv
module frc_timer
  import frc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              cap_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              cmp_o,
  output logic              irq_o
);
  localparam int CW = 2 * BUS_W;

  logic [NREG-1:0]              rsel, wsel;
  logic [CW-1:0]                cnt, cmp_val;
  logic                         wrap, match;
  logic [NVIEW-1:0]             rd_hi, rd_lo;
  logic [NVIEW-1:0][BUS_W-1:0]  lo_view;
  logic [NFLAG-1:0]             fset, fclr, flags;
  logic [NFLAG-1:0]             en_q;
  logic                         olvl_q;
  logic                         capin_q;
  logic [CW-1:0]                cap_q;
  logic                         cap_edge;

  assign rsel = rd_i ? (NREG'(1) << addr_i) : '0;
  assign wsel = wr_i ? (NREG'(1) << addr_i) : '0;

  assign rd_hi = {rsel[A_ALTH], rsel[A_CNTH]};
  assign rd_lo = {rsel[A_ALTL], rsel[A_CNTL]};

  frc_counter #(.DW(BUS_W), .NV(NVIEW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .rd_hi_i(rd_hi), .rd_lo_i(rd_lo),
    .cnt_o(cnt), .wrap_o(wrap), .lo_o(lo_view)
  );

  frc_compare #(.DW(BUS_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_i(cnt),
    .wr_hi_i(wsel[A_CMPH]), .wr_lo_i(wsel[A_CMPL]), .wdata_i(wdata_i),
    .olvl_i(olvl_q), .cmp_o(cmp_val), .match_o(match), .pin_o(cmp_o)
  );

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      olvl_q <= 1'b0;
    end else if (wsel[A_CTRL]) begin
      en_q   <= wdata_i[BUS_W-1 -: NFLAG];
      olvl_q <= wdata_i[0];
    end
  end

  // capture
  assign cap_edge = cap_i && !capin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capin_q <= 1'b0;
      cap_q   <= '0;
    end else begin
      capin_q <= cap_i;
      if (cap_edge) cap_q <= cnt;
    end
  end

  // flags
  assign fset[FI_TO] = wrap;
  assign fset[FI_OC] = match;
  assign fset[FI_IC] = cap_edge;
  assign fclr[FI_TO] = rsel[A_CNTL];
  assign fclr[FI_OC] = wsel[A_CMPL];
  assign fclr[FI_IC] = rsel[A_CAPL];

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    frc_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(fset[g]),
      .look_i(rsel[A_STAT]), .clr_i(fclr[g]), .flag_o(flags[g])
    );
  end

  assign irq_o = |(flags & en_q);

  // read mux
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o = {en_q, {(BUS_W-NFLAG-1){1'b0}}, olvl_q};
      A_STAT: rdata_o = {flags, {(BUS_W-NFLAG){1'b0}}};
      A_CNTH: rdata_o = cnt[CW-1:BUS_W];
      A_CNTL: rdata_o = lo_view[0];
      A_ALTH: rdata_o = cnt[CW-1:BUS_W];
      A_ALTL: rdata_o = lo_view[1];
      A_CAPH: rdata_o = cap_q[CW-1:BUS_W];
      A_CAPL: rdata_o = cap_q[BUS_W-1:0];
      A_CMPH: rdata_o = cmp_val[CW-1:BUS_W];
      A_CMPL: rdata_o = cmp_val[BUS_W-1:0];
      default: rdata_o = '0;
    endcase
  end

  // R3: wrap always raises overflow
  p_wrap_sets_tof_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flags[FI_TO]);

  // R5: alternate low read leaves overflow untouched
  p_alt_keeps_tof_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsel[A_ALTL] |=> flags[FI_TO] == ($past(flags[FI_TO]) || $past(wrap)));

  // R2: status writes alter no flag
  p_stat_wr_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wsel[A_STAT] && !rd_i && !(|fset) |=> flags == $past(flags));

  // R11: no enables, no request
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en_q == '0 |-> !irq_o);

  // R1: unimplemented status bits
  p_stat_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i && addr_i == A_STAT |-> rdata_o[BUS_W-NFLAG-1:0] == '0);
endmodule

// File: tb/frc_timer_tb_top.sv
`timescale 1ns/1ps
module frc_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, cap_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       cmp_o, irq_o;

  always #2.5 clk = ~clk;

  frc_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cap_i(cap_i),
    .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .cmp_o(cmp_o), .irq_o(irq_o)
  );

  int n_cmp = 0, n_bad = 0;
  string req = "R2";
  logic [7:0] got;

  // behavioural model state
  int   m_cnt, m_cmp, m_capv, m_buf0, m_buf1;
  bit   m_lat0, m_lat1, m_inh, m_out, m_capq;
  bit   m_fic, m_foc, m_fto, m_aic, m_aoc, m_ato;
  int   m_ctrl;
  bit   known = 0;

  task automatic model_reset();
    m_cnt = 0; m_cmp = 16'hFFFF; m_capv = 0; m_buf0 = 0; m_buf1 = 0;
    m_lat0 = 0; m_lat1 = 0; m_inh = 0; m_out = 0; m_capq = 0;
    m_aic = 0; m_aoc = 0; m_ato = 0; m_ctrl = 0;
  endtask

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_ctrl;
      1: return (int'(m_fic) << 7) | (int'(m_foc) << 6) | (int'(m_fto) << 5);
      2, 4: return (m_cnt >> 8) & 255;
      3: return m_lat0 ? m_buf0 : (m_cnt & 255);
      5: return m_lat1 ? m_buf1 : (m_cnt & 255);
      6: return (m_capv >> 8) & 255;
      7: return m_capv & 255;
      8: return (m_cmp >> 8) & 255;
      9: return m_cmp & 255;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit r, input bit w, input int a, input int d,
                     input bit t, input bit c);
    bit ev_wrap, ev_match, ev_cap;
    int nxt;
    bit irq_e;
    @(negedge clk);
    rd_i = r; wr_i = w; addr_i = 4'(a); wdata_i = 8'(d); tick_i = t; cap_i = c;
    #1;
    if (!rst_n) model_reset();
    if (r && a == 1 && !known) begin
      m_fic = rdata_o[7]; m_foc = rdata_o[6]; m_fto = rdata_o[5];
      known = 1;
    end
    if (r) chk("rdata", int'(rdata_o), exp_rd(a));
    irq_e = (m_fic && m_ctrl[7]) || (m_foc && m_ctrl[6]) || (m_fto && m_ctrl[5]);
    if (known) chk("irq", int'(irq_o), int'(irq_e));
    chk("cmp_o", int'(cmp_o), int'(m_out));
    got = rdata_o;
    if (!rst_n) return;
    // model the edge
    nxt      = (m_cnt + int'(t)) & 16'hFFFF;
    ev_wrap  = t && m_cnt == 16'hFFFF;
    ev_match = t && !m_inh && nxt == m_cmp;
    ev_cap   = c && !m_capq;
    if (r && a == 1) begin
      m_aic = m_fic; m_aoc = m_foc; m_ato = m_fto;
    end
    if (ev_cap) m_fic = 1; else if (r && a == 7 && m_aic) m_fic = 0;
    if (r && a == 7) m_aic = 0;
    if (ev_match) m_foc = 1; else if (w && a == 9 && m_aoc) m_foc = 0;
    if (w && a == 9) m_aoc = 0;
    if (ev_wrap) m_fto = 1; else if (r && a == 3 && m_ato) m_fto = 0;
    if (r && a == 3) m_ato = 0;
    if (r && a == 2) begin m_buf0 = m_cnt & 255; m_lat0 = 1; end
    else if (r && a == 3) m_lat0 = 0;
    if (r && a == 4) begin m_buf1 = m_cnt & 255; m_lat1 = 1; end
    else if (r && a == 5) m_lat1 = 0;
    if (ev_cap) m_capv = m_cnt;
    m_capq = c;
    if (ev_match) m_out = m_ctrl[0];
    if (w && a == 0) m_ctrl = d & 8'hE1;
    if (w && a == 8) begin m_cmp = (m_cmp & 255) | ((d & 255) << 8); m_inh = 1; end
    else if (w && a == 9) begin m_cmp = (m_cmp & 16'hFF00) | (d & 255); m_inh = 0; end
    m_cnt = nxt;
  endtask

  task automatic rdr(input int a);          cyc(1, 0, a, 0, 0, 0); endtask
  task automatic wrr(input int a, input int d); cyc(0, 1, a, d, 0, 0); endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int h1, h2, lo, snap;
    model_reset();
    m_fic = 0; m_foc = 0; m_fto = 0;
    repeat (3) cyc(0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    req = "R1"; rdr(1);                     // sync flag model
    req = "R2"; rdr(2); chk("reset counter high", int'(got), 0);
    rdr(9); chk("reset compare low", int'(got), 8'hFF);
    rdr(12); req = "R1"; chk("unmapped reads zero", int'(got), 0);
    // clear any power-up flags through the handshake
    rdr(1); rdr(3); rdr(7); wrr(9, 8'hFF); rdr(1);
    chk("flags cleared", int'(got), 0);

    // R8: compare match with level 1
    req = "R8";
    wrr(0, 8'h01); rdr(0); req = "R11"; chk("ctrl readback", int'(got), 8'h01);
    req = "R8";
    wrr(8, 8'h00); wrr(9, 8'h20);
    ticks(40);
    rdr(1); chk("OCF after match", int'(got) & 8'h40, 8'h40);
    chk("cmp_o level", int'(cmp_o), 1);
    wrr(9, 8'h20); rdr(1); chk("OCF cleared", int'(got) & 8'h40, 0);

    // R9: high-byte write inhibits
    req = "R9";
    wrr(9, 8'h40); wrr(8, 8'h00); wrr(0, 8'h00);
    ticks(40);
    rdr(1); chk("no match while inhibited", int'(got) & 8'h40, 0);
    chk("pin held", int'(cmp_o), 1);
    wrr(9, 8'h60); ticks(40);
    rdr(1); chk("match after low write", int'(got) & 8'h40, 8'h40);
    req = "R8"; chk("cmp_o level 0", int'(cmp_o), 0);

    // R6: coherent reads
    req = "R6";
    rdr(2); h1 = got; snap = m_cnt & 255;
    ticks(5); rdr(3); chk("buffered low", int'(got), snap);
    rdr(3); chk("live low after release", int'(got), m_cnt & 255);
    // R5: alt view matches main
    req = "R5";
    rdr(2); h1 = got; rdr(4); h2 = got; chk("alt high equals main", h2, h1);

    // R7: capture
    req = "R7";
    ticks(7); snap = m_cnt;
    cyc(0, 0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0, 0);
    rdr(1); chk("ICF set", int'(got) & 8'h80, 8'h80);
    rdr(6); chk("capture high", int'(got), (snap >> 8) & 255);
    rdr(7); chk("capture low", int'(got), snap & 255);
    rdr(1); chk("ICF cleared", int'(got) & 8'h80, 0);

    // R10: unarmed access does not clear; set beats clear
    req = "R10";
    cyc(0, 0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0, 0);
    rdr(7); rdr(1); chk("unarmed read kept ICF", int'(got) & 8'h80, 8'h80);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(1, 0, 7, 0, 0, 1); cyc(0, 0, 0, 0, 0, 0);
    rdr(1); chk("set wins over clear", int'(got) & 8'h80, 8'h80);

    // R11: interrupt enables
    req = "R11";
    wrr(0, 8'h20); cyc(0, 0, 0, 0, 0, 0); chk("irq off (TOF en only)", int'(irq_o), 0);
    wrr(0, 8'h80); cyc(0, 0, 0, 0, 0, 0); chk("irq on (ICF en)", int'(irq_o), 1);
    wrr(0, 8'h00);

    // R2: status write ignored, reset keeps flags
    req = "R2";
    wrr(1, 8'h00); rdr(1); chk("status write ignored", int'(got) & 8'h80, 8'h80);
    rst_n = 1'b0; cyc(0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    rdr(1); chk("flag kept over reset", int'(got) & 8'h80, 8'h80);
    rdr(2); chk("counter reset", int'(got), 0);
    rdr(7); rdr(1);

    // R3: overflow
    req = "R3";
    ticks(65536);
    rdr(1); chk("TOF after wrap", int'(got) & 8'h20, 8'h20);
    rdr(2); chk("counter wrapped to 0", int'(got), 0);
    // R5: alternate pair does not clear armed TOF
    req = "R5";
    rdr(1); rdr(4); rdr(5);
    rdr(1); chk("alt read kept TOF", int'(got) & 8'h20, 8'h20);
    // R4: armed main low read clears
    req = "R4";
    rdr(3); rdr(1); chk("TOF cleared", int'(got) & 8'h20, 0);
    finish_run();
  end
endmodule